// File: doc/BRIEF.md
# Bidirectional Half-Duplex Line Repeater

This block sits between a host-side open-drain data line and a card-side open-drain data line and copies a low from one side to the other. Both lines idle high. Whichever side falls first becomes the master; the block then ignores falling edges on the other side, which is the slave. After a fixed delay of `TD_CYCLES` system clocks it pulls the slave low. When the master goes back high, it releases the slave and fires a short active pull-up strobe on the slave side for `TD_CYCLES` clocks. It then returns to idle.

The inputs are the sampled levels of both lines, a chip-select and a session enable from the card sequencer. The outputs are a drive-low enable and a boost strobe for each side. Both line inputs pass through a synchronizer before edge detection. An anti-latch rule sends the block back to idle whenever both lines are seen high, so the line can never stick low. One instance serves each of the data line and the two auxiliary lines.

States: OFF (no session), IDLE, HWAIT / HDRV / HBST (host is master: delay, drive card, boost card), CWAIT / CDRV / CBST (card is master: delay, drive host, boost host) and CONF (conflict). The transitions are:
- OFF goes to IDLE when the session enable rises.
- IDLE goes to CWAIT on a card fall, or to HWAIT on a host fall while selected. The card fall wins if both happen together.
- A WAIT state goes to its DRV state when the delay expires. It goes back to IDLE if both lines are high.
- A DRV state goes to its BST state when the master line is high again.
- A BST state goes to IDLE when the delay expires and both lines are high. If either line is still low, it goes to CONF.
- CONF goes to IDLE when both lines are high.
- Any state goes to OFF when the session enable is low.

Top module: `line_repeater`

## Requirements
- R1: During and after reset, and whenever the session enable is low, `card_drive_low` is 1 and the other three outputs are 0. In IDLE all four outputs are 0.
- R2: If the host line falls first (level 1 to 0) in IDLE, `card_drive_low` rises exactly `TD_CYCLES+3` clock edges after the input change (two synchronizer stages, one edge-detect edge, `TD_CYCLES` delay). `host_drive_low` stays 0.
- R3: If the card line falls first in IDLE and chip-select is 1, `host_drive_low` rises `TD_CYCLES+3` edges after the change. `card_drive_low` stays 0.
- R4: If both lines fall in the same cycle, the card side becomes master.
- R5: While one side is master, a low appearing on the slave side never causes the slave-to-master drive.
- R6: Three clock edges after the master line returns high, the slave drive-low is released. The slave boost strobe is then 1 for exactly `TD_CYCLES` cycles, after which all outputs are 0.
- R7: If both synchronized lines are high during the delay, the block returns to IDLE and no drive occurs, so a master pulse shorter than the delay is not forwarded.
- R8: If either line is still low when a boost ends, no drive or boost is asserted until both lines are high. The block then returns to IDLE and transfers normally again.
- R9: When chip-select is 0, `host_drive_low` and `host_boost` are never 1, and host-side falls start no transfer.
- R10: While the session enable is 0, `card_drive_low` stays 1 and falls on either line start no transfer.
- R11: The delay counter restarts for every new mastership, so back-to-back transfers show identical latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_in | input | 1 | Sampled host-side line level (1 = high) |
| card_in | input | 1 | Sampled card-side line level (1 = high) |
| chip_sel | input | 1 | 1 = host side connected |
| session_en | input | 1 | 1 = card session active |
| host_drive_low | output | 1 | Pull host line low |
| card_drive_low | output | 1 | Pull card line low |
| host_boost | output | 1 | Active pull-up strobe, host side |
| card_boost | output | 1 | Active pull-up strobe, card side |

## Verification
The assertions assume the line inputs reflect the block's own drive: a side the block pulls low reads low. The bench models each line as the wired-AND of the block's drive and an external driver.

They also assume that master pulses, and the gaps between them, last many more cycles than `TD_CYCLES`. This matches a toggle rate of about 200 kHz. The stimulus holds every external low and high for at least ten cycles, except the one deliberate glitch. Chip-select and session enable change only while the lines are idle.

// File: rtl/lr_pkg.sv
package lr_pkg;
    localparam int HOST = 0;
    localparam int CARD = 1;
    localparam int LANES = 2;

    typedef enum logic [3:0] {
        S_OFF,
        S_IDLE,
        S_HWAIT,
        S_HDRV,
        S_HBST,
        S_CWAIT,
        S_CDRV,
        S_CBST,
        S_CONF
    } lr_state_e;
endpackage

// File: rtl/lr_sync.sv
module lr_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[g] <= '1;
                    else        stage[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage[g] <= '1;
                    else        stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign q = stage[STAGES-1];
endmodule

// File: rtl/lr_fall_det.sv
module lr_fall_det #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev <= '1;
        else        prev <= lvl;
    end

    assign fall = prev & ~lvl;
endmodule

// File: rtl/lr_timer.sv
module lr_timer #(
    parameter int TD_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic done
);
    localparam int CW = $clog2(TD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(TD_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         cnt <= '0;
        else if (clr)       cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign done = !clr && (cnt == LAST);
endmodule

// File: rtl/line_repeater.sv
module line_repeater
    import lr_pkg::*;
#(
    parameter int TD_CYCLES   = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_in,
    input  logic card_in,
    input  logic chip_sel,
    input  logic session_en,
    output logic host_drive_low,
    output logic card_drive_low,
    output logic host_boost,
    output logic card_boost
);
    logic [LANES-1:0] raw, lvl, fall;
    logic             both_high, td_done, td_clr;
    lr_state_e        state, nxt;

    assign raw[HOST] = host_in;
    assign raw[CARD] = card_in;

    lr_sync #(.W(LANES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(lvl)
    );

    lr_fall_det #(.W(LANES)) u_fall (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .fall(fall)
    );

    assign td_clr = !(state == S_HWAIT || state == S_CWAIT ||
                      state == S_HBST  || state == S_CBST);

    lr_timer #(.TD_CYCLES(TD_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(td_clr), .done(td_done)
    );

    assign both_high = &lvl;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_OFF:   if (session_en) nxt = S_IDLE;
            S_IDLE: begin
                if (fall[CARD])                   nxt = S_CWAIT;
                else if (fall[HOST] && chip_sel)  nxt = S_HWAIT;
            end
            S_HWAIT: begin
                if (both_high)    nxt = S_IDLE;
                else if (td_done) nxt = S_HDRV;
            end
            S_HDRV:  if (lvl[HOST]) nxt = S_HBST;
            S_HBST:  if (td_done) nxt = both_high ? S_IDLE : S_CONF;
            S_CWAIT: begin
                if (both_high)    nxt = S_IDLE;
                else if (td_done) nxt = S_CDRV;
            end
            S_CDRV:  if (lvl[CARD]) nxt = S_CBST;
            S_CBST:  if (td_done) nxt = both_high ? S_IDLE : S_CONF;
            S_CONF:  if (both_high) nxt = S_IDLE;
            default: nxt = S_OFF;
        endcase
        if (!session_en) nxt = S_OFF;
    end

    always_comb begin
        card_drive_low = (state == S_OFF) || (state == S_HDRV);
        host_drive_low = (state == S_CDRV) && chip_sel;
        card_boost     = (state == S_HBST);
        host_boost     = (state == S_CBST) && chip_sel;
    end
endmodule

// File: rtl/line_repeater_chk.sv
module line_repeater_chk #(
    parameter int TD_CYCLES = 5
) (
    input logic clk,
    input logic rst_n,
    input logic chip_sel,
    input logic session_en,
    input logic host_drive_low,
    input logic card_drive_low,
    input logic host_boost,
    input logic card_boost
);
    localparam int RW = $clog2(TD_CYCLES + 2) + 1;

    logic [RW-1:0] card_run, host_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            card_run <= '0;
            host_run <= '0;
        end else begin
            card_run <= card_boost ? card_run + 1'b1 : '0;
            host_run <= host_boost ? host_run + 1'b1 : '0;
        end
    end

    // R5: only one side is ever pulled low by the block
    assert_one_side_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_drive_low && card_drive_low));

    // R9: deselected host side is never pulled low
    assert_deselect_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_sel |-> !host_drive_low && !host_boost);

    // R10: no session means the card side is held low on the next cycle
    assert_session_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !session_en |=> card_drive_low);

    // R6: boost strobes never exceed the delay length
    assert_boost_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (card_boost |-> card_run < RW'(TD_CYCLES)) and
        (host_boost |-> host_run < RW'(TD_CYCLES)));

    // R6: a side is never boosted while being pulled low
    assert_boost_not_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(card_boost && card_drive_low) && !(host_boost && host_drive_low));
endmodule

bind line_repeater line_repeater_chk #(.TD_CYCLES(TD_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .chip_sel(chip_sel), .session_en(session_en),
    .host_drive_low(host_drive_low), .card_drive_low(card_drive_low),
    .host_boost(host_boost), .card_boost(card_boost)
);

// File: tb/tb_line_repeater.sv
module tb_line_repeater;
    localparam int TD = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic chip_sel = 1'b1;
    logic session_en = 1'b0;
    logic host_ext = 1'b0;
    logic card_ext = 1'b0;
    logic host_in, card_in;
    logic host_drive_low, card_drive_low, host_boost, card_boost;
    int   checks = 0;
    int   errors = 0;

    always #10 clk = ~clk;

    assign host_in = ~(host_ext | host_drive_low);
    assign card_in = ~(card_ext | card_drive_low);

    line_repeater #(.TD_CYCLES(TD)) dut (
        .clk(clk), .rst_n(rst_n), .host_in(host_in), .card_in(card_in),
        .chip_sel(chip_sel), .session_en(session_en),
        .host_drive_low(host_drive_low), .card_drive_low(card_drive_low),
        .host_boost(host_boost), .card_boost(card_boost)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic outs_zero(input string req);
        chk(req, {host_drive_low, card_drive_low, host_boost, card_boost}, 0);
    endtask

    task automatic watch(input int n, output int hd, output int cd);
        hd = 0;
        cd = 0;
        for (int i = 0; i < n; i++) begin
            step(1);
            hd += int'(host_drive_low);
            cd += int'(card_drive_low);
        end
    endtask

    task automatic boost_len(input bit card_side, output int len);
        len = 0;
        for (int i = 0; i < 50; i++) begin
            if (card_side ? card_boost : host_boost) len++;
            else if (len > 0) break;
            step(1);
        end
    endtask

    task automatic t_reset;
        chk("R1 reset card held", int'(card_drive_low), 1);
        chk("R1 reset host", int'(host_drive_low | host_boost | card_boost), 0);
        rst_n = 1'b1;
        step(2);
        session_en = 1'b1;
        step(5);
        outs_zero("R1 idle outputs");
    endtask

    task automatic t_host_xfer(input string tag);
        int len;
        host_ext = 1'b1;
        step(TD + 2);
        chk({tag, " R2 card before delay"}, int'(card_drive_low), 0);
        step(1);
        chk({tag, " R2 card drive latency"}, int'(card_drive_low), 1);
        chk({tag, " R2 host not driven"}, int'(host_drive_low), 0);
        step(10);
        host_ext = 1'b0;
        step(2);
        chk({tag, " R6 drive held"}, int'(card_drive_low), 1);
        step(1);
        chk({tag, " R6 drive released"}, int'(card_drive_low), 0);
        boost_len(1'b1, len);
        chk({tag, " R6 card boost width"}, len, TD);
        step(2);
        outs_zero({tag, " R6 back to idle"});
    endtask

    task automatic t_card_xfer;
        int len;
        card_ext = 1'b1;
        step(TD + 2);
        chk("R3 host before delay", int'(host_drive_low), 0);
        step(1);
        chk("R3 host drive latency", int'(host_drive_low), 1);
        chk("R3 card not driven", int'(card_drive_low), 0);
        step(10);
        card_ext = 1'b0;
        step(3);
        chk("R6 host released", int'(host_drive_low), 0);
        boost_len(1'b0, len);
        chk("R6 host boost width", len, TD);
        step(2);
        outs_zero("R6 card xfer idle");
    endtask

    task automatic t_simultaneous;
        host_ext = 1'b1;
        card_ext = 1'b1;
        step(TD + 3);
        chk("R4 card wins host driven", int'(host_drive_low), 1);
        chk("R4 card wins card free", int'(card_drive_low), 0);
        step(10);
        host_ext = 1'b0;
        card_ext = 1'b0;
        step(TD + 10);
        outs_zero("R4 idle after tie");
    endtask

    task automatic t_lockout;
        int hd, cd;
        host_ext = 1'b1;
        step(1);
        card_ext = 1'b1;
        watch(TD + 15, hd, cd);
        chk("R5 slave fall ignored", hd, 0);
        chk("R5 host still master", int'(card_drive_low), 1);
        card_ext = 1'b0;
        step(10);
        host_ext = 1'b0;
        watch(TD + 10, hd, cd);
        chk("R5 no reverse drive", hd, 0);
        outs_zero("R5 idle after lockout");
    endtask

    task automatic t_glitch;
        int hd, cd;
        host_ext = 1'b1;
        step(1);
        host_ext = 1'b0;
        watch(TD + 20, hd, cd);
        chk("R7 short pulse not forwarded", cd, 0);
        outs_zero("R7 idle after glitch");
    endtask

    task automatic t_conflict;
        int hd, cd;
        host_ext = 1'b1;
        step(TD + 5);
        card_ext = 1'b1;
        step(5);
        host_ext = 1'b0;
        step(TD + 5);
        outs_zero("R8 conflict quiet");
        host_ext = 1'b1;
        watch(TD + 10, hd, cd);
        chk("R8 no card drive in conflict", cd, 0);
        chk("R8 no host drive in conflict", hd, 0);
        host_ext = 1'b0;
        card_ext = 1'b0;
        step(10);
        outs_zero("R8 recovered idle");
        t_host_xfer("R8 after conflict");
    endtask

    task automatic t_deselect;
        int hd, cd;
        chip_sel = 1'b0;
        step(2);
        card_ext = 1'b1;
        watch(TD + 15, hd, cd);
        chk("R9 host never driven", hd, 0);
        card_ext = 1'b0;
        watch(TD + 10, hd, cd);
        chk("R9 host boost silent", int'(host_boost), 0);
        host_ext = 1'b1;
        watch(TD + 15, hd, cd);
        chk("R9 host fall ignored", cd, 0);
        host_ext = 1'b0;
        step(10);
        chip_sel = 1'b1;
        step(2);
        outs_zero("R9 idle reselected");
    endtask

    task automatic t_session;
        int hd, cd;
        session_en = 1'b0;
        step(1);
        chk("R10 card held low", int'(card_drive_low), 1);
        host_ext = 1'b1;
        watch(TD + 15, hd, cd);
        chk("R10 card held throughout", cd, TD + 15);
        chk("R10 host never driven", hd, 0);
        host_ext = 1'b0;
        step(5);
        session_en = 1'b1;
        step(5);
        outs_zero("R10 idle after session");
    endtask

    initial begin
        step(3);
        t_reset();
        t_host_xfer("R11 first");
        step(5);
        t_host_xfer("R11 second");
        step(5);
        t_card_xfer();
        step(5);
        t_simultaneous();
        step(5);
        t_lockout();
        step(5);
        t_glitch();
        t_host_xfer("R7 after glitch");
        step(5);
        t_conflict();
        step(5);
        t_deselect();
        step(5);
        t_session();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule